// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block sits between three timer/counters and the CPU's interrupt logic. Each timer reports its events (overflows, compare matches, an input capture) as single-cycle pulses. The block catches each pulse in a sticky flag bit of an 8-bit flag register. An 8-bit mask register beside the flags selects which sources may interrupt. Software reaches both registers through a small register port. A one-bit select picks the register, reads are combinational, and writes take effect at the clock edge.

When the global interrupt enable input is high and at least one source has both its flag and its mask bit set, the block raises a registered interrupt request. Beside the request it drives the fixed vector number of the most urgent pending source. When the CPU acknowledges, the block clears the flag of the presented source and leaves all other flags alone. Software can also clear flags at any time by writing ones to them.

Top module: `timer_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `irqReq` is 0 and `irqVec` is 0.
- R2: A pulse on `evtPulse[i]` sets flag bit i at the next clock edge. The flag then stays set until it is cleared. The bit layout from bit 7 down is: timer2 compare, timer2 overflow, timer1 capture, timer1 compare A, timer1 compare B, timer1 overflow, reserved, timer0 overflow.
- R3: A write with `regSel`=0 clears every flag bit where `regWrData` holds a one. Flag bits where `regWrData` holds a zero keep their value.
- R4: A write with `regSel`=1 loads the mask register. Mask bit i gates source i, using the same positions as the flags.
- R5: Bit 1 is reserved in both registers. It always reads 0, and neither writes nor `evtPulse[1]` can set it.
- R6: `irqReq` is registered. In the cycle after an edge, it is 1 exactly when `gie` was 1 at that edge and some bit is set in both the flag and the mask registers as they stand after that edge.
- R7: Vector numbers are fixed per bit: bit 7 is 3, bit 6 is 4, bit 5 is 5, bit 4 is 6, bit 3 is 7, bit 2 is 8 and bit 0 is 9. `irqVec` is 0 while `irqReq` is 0.
- R8: When several sources are pending, `irqVec` shows the lowest vector number among them.
- R9: `irqAck` sampled high while `irqReq` is 1 clears only the flag of the vector being presented. While `irqReq` is 0, `irqAck` has no effect.
- R10: If a source pulse arrives in the same cycle as a clear of that flag, whether by write or by acknowledge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtPulse | input | 8 | Single-cycle source event pulses, one per flag bit |
| regSel | input | 1 | Register select: 0 selects the flag register, 1 selects the mask register |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register (combinational) |
| gie | input | 1 | Global interrupt enable |
| irqAck | input | 1 | CPU acknowledge of the presented vector |
| irqReq | output | 1 | Registered interrupt request |
| irqVec | output | 4 | Registered vector number |

## Verification
The bench builds the block with its default parameters: an 8-bit flag register, a 4-bit vector and a vector base of 3. With these defaults the whole vector range from 3 to 9 can be reached, including vector 9 for the timer0 overflow at bit 0 below the reserved bit. Random traffic makes events, write-one-to-clear, mask rewrites and acknowledges collide in the same cycle. Directed cases pin down priority among all sources, acknowledge without a request, and an event that lands together with a clear.

// File: rtl/timer_irq_pkg.sv
package timer_irq_pkg;
  localparam int FLAG_W   = 8;
  localparam int VEC_W    = 4;
  localparam int RSVD_BIT = 1;
  localparam logic [FLAG_W-1:0] LIVE_MASK = ~(FLAG_W'(1) << RSVD_BIT);

  // strobes from control to datapath
  typedef struct packed {
    logic              flagWr;
    logic              maskWr;
    logic [FLAG_W-1:0] ackClr;
  } strobe_t;

  // fixed vector of flag bit idx: bits above the reserved bit count down
  // from base, bits below it follow after
  function automatic logic [VEC_W-1:0] vecOf(input int idx, input int base);
    int v;
    if (idx > RSVD_BIT) v = base + (FLAG_W - 1 - idx);
    else                v = base + (FLAG_W - 2 - idx);
    return VEC_W'(v);
  endfunction
endpackage

// File: rtl/timer_irq_dp.sv
module timer_irq_dp
  import timer_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [FLAG_W-1:0] evtPulse,
  input  logic [FLAG_W-1:0] wrData,
  input  logic              regSel,
  output logic [FLAG_W-1:0] rdData,
  output logic [FLAG_W-1:0] flagQ,
  output logic [FLAG_W-1:0] maskQ,
  output logic [FLAG_W-1:0] flagNext,
  output logic [FLAG_W-1:0] maskNext
);
  logic [FLAG_W-1:0] clrMask;

  assign clrMask = (stb.flagWr ? wrData : '0) | stb.ackClr;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (i == RSVD_BIT) begin : g_rsvd
      assign flagNext[i] = 1'b0;
      assign maskNext[i] = 1'b0;
    end else begin : g_live
      // a new event outranks any clear in the same cycle
      assign flagNext[i] = evtPulse[i] | (flagQ[i] & ~clrMask[i]);
      assign maskNext[i] = stb.maskWr ? wrData[i] : maskQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      flagQ <= flagNext;
      maskQ <= maskNext;
    end
  end

  assign rdData = regSel ? maskQ : flagQ;
endmodule

// File: rtl/timer_irq_ctl.sv
module timer_irq_ctl
  import timer_irq_pkg::*;
#(
  parameter int VEC_BASE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic              irqAck,
  input  logic              gie,
  input  logic [FLAG_W-1:0] flagNext,
  input  logic [FLAG_W-1:0] maskNext,
  output strobe_t           stb,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVec
);
  logic [FLAG_W-1:0] pendNext;
  logic [FLAG_W-1:0] bestOh;
  logic [FLAG_W-1:0] selBitQ;
  logic [VEC_W-1:0]  bestVec;

  always_comb begin
    stb.flagWr = regWrEn & ~regSel;
    stb.maskWr = regWrEn & regSel;
    stb.ackClr = (irqAck && irqReq) ? selBitQ : '0;
  end

  assign pendNext = flagNext & maskNext & {FLAG_W{gie}};

  // pick the pending source with the smallest vector number
  always_comb begin
    bestVec = '1;
    bestOh  = '0;
    for (int i = 0; i < FLAG_W; i++) begin
      if (pendNext[i] && (bestOh == '0 || vecOf(i, VEC_BASE) < bestVec)) begin
        bestVec = vecOf(i, VEC_BASE);
        bestOh  = FLAG_W'(1) << i;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq  <= 1'b0;
      irqVec  <= '0;
      selBitQ <= '0;
    end else begin
      irqReq  <= |pendNext;
      irqVec  <= (|pendNext) ? bestVec : '0;
      selBitQ <= bestOh;
    end
  end
endmodule

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl
  import timer_irq_pkg::*;
#(
  parameter int VEC_BASE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] evtPulse,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [FLAG_W-1:0] regWrData,
  output logic [FLAG_W-1:0] regRdData,
  input  logic              gie,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVec
);
  strobe_t           stb;
  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] maskQ;
  logic [FLAG_W-1:0] flagNext;
  logic [FLAG_W-1:0] maskNext;
  logic [FLAG_W-1:0] ackMask;

  assign ackMask = stb.ackClr;

  timer_irq_ctl #(.VEC_BASE(VEC_BASE)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .irqAck   (irqAck),
    .gie      (gie),
    .flagNext (flagNext),
    .maskNext (maskNext),
    .stb      (stb),
    .irqReq   (irqReq),
    .irqVec   (irqVec)
  );

  timer_irq_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .evtPulse (evtPulse),
    .wrData   (regWrData),
    .regSel   (regSel),
    .rdData   (regRdData),
    .flagQ    (flagQ),
    .maskQ    (maskQ),
    .flagNext (flagNext),
    .maskNext (maskNext)
  );
endmodule

// File: rtl/timer_irq_chk.sv
module timer_irq_chk
  import timer_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              gie,
  input logic              irqAck,
  input logic              irqReq,
  input logic [VEC_W-1:0]  irqVec,
  input logic              regWrEn,
  input logic              regSel,
  input logic [FLAG_W-1:0] evtPulse,
  input logic [FLAG_W-1:0] flagQ,
  input logic [FLAG_W-1:0] maskQ,
  input logic [FLAG_W-1:0] ackMask
);
  // R5: reserved bit never set in either register
  a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rstN)
    !flagQ[RSVD_BIT] && !maskQ[RSVD_BIT]);

  // R6: request mirrors registered state and last sampled gie
  a_r6_req_match: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == ($past(gie) && ((flagQ & maskQ) != '0)));

  // R7: idle vector is zero
  a_r7_idle_vec: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> irqVec == '0);

  // R2: without a clear, flags never drop
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWrEn && !regSel) && !(irqAck && irqReq)) |=>
      ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R9: an acknowledge clears the presented flag
  a_r9_ack_clear: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq && ((evtPulse & ackMask) == '0)) |=>
      ((flagQ & $past(ackMask)) == '0));

  // R9: an acknowledge clears at most one flag
  a_r9_ack_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackMask));

  // R10: an event always leaves its flag set
  a_r10_evt_wins: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & LIVE_MASK) != '0) |=>
      ((flagQ & $past(evtPulse & LIVE_MASK)) == $past(evtPulse & LIVE_MASK)));
endmodule

bind timer_irq_ctrl timer_irq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .gie      (gie),
  .irqAck   (irqAck),
  .irqReq   (irqReq),
  .irqVec   (irqVec),
  .regWrEn  (regWrEn),
  .regSel   (regSel),
  .evtPulse (evtPulse),
  .flagQ    (flagQ),
  .maskQ    (maskQ),
  .ackMask  (ackMask)
);

// File: tb/tb_timer_irq_ctrl.sv
module tb_timer_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evtPulse = '0;
  logic       regSel = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       gie = 1'b0;
  logic       irqAck = 1'b0;
  logic       irqReq;
  logic [3:0] irqVec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mFlag = '0, mMask = '0;
  logic       mReq = 1'b0;
  logic [3:0] mVec = '0;

  always #2.5 clk = ~clk;

  timer_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regSel(regSel),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .gie(gie), .irqAck(irqAck), .irqReq(irqReq), .irqVec(irqVec));

  function automatic logic [3:0] vecFor(int b);
    case (b)
      7: return 4'd3;  6: return 4'd4;  5: return 4'd5;  4: return 4'd6;
      3: return 4'd7;  2: return 4'd8;  0: return 4'd9;
      default: return 4'd0;
    endcase
  endfunction

  function automatic int bitFor(logic [3:0] v);
    case (v)
      4'd3: return 7; 4'd4: return 6; 4'd5: return 5; 4'd6: return 4;
      4'd7: return 3; 4'd8: return 2; 4'd9: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic logic [3:0] prioVec(logic [7:0] p);
    logic [3:0] v = 4'd0;
    for (int b = 0; b < 8; b++) if (p[b]) v = vecFor(b);  // higher bit = lower vector
    return v;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check read data, clock, update model, check outputs
  task automatic cyc(input logic [7:0] ev, input logic wr, input logic sel,
                     input logic [7:0] d, input logic ack, input logic g);
    logic [7:0] clr;
    evtPulse = ev; regWrEn = wr; regSel = sel; regWrData = d; irqAck = ack; gie = g;
    #1;
    chk(regRdData, sel ? mMask : mFlag, sel ? "R4 mask read" : "R2/R3 flag read");
    @(posedge clk);
    clr = (wr && !sel) ? d : 8'h00;
    if (ack && mReq && bitFor(mVec) >= 0) clr[bitFor(mVec)] = 1'b1;
    mFlag = ((mFlag & ~clr) | ev) & 8'hFD;
    if (wr && sel) mMask = d & 8'hFD;
    mReq = g && ((mFlag & mMask) != 0);
    mVec = mReq ? prioVec(mFlag & mMask) : 4'd0;
    @(negedge clk);
    chk({7'd0, irqReq}, {7'd0, mReq}, "R6 irqReq");
    chk({4'd0, irqVec}, {4'd0, mVec}, "R7/R8 irqVec");
  endtask

  task automatic idle(); cyc(8'h00, 0, 0, 8'h00, 0, gie); endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(regRdData, 8'h00, "R1 flags at reset");
    chk({7'd0, irqReq}, 8'h00, "R1 irqReq at reset");
    chk({4'd0, irqVec}, 8'h00, "R1 irqVec at reset");
    rstN = 1'b1;
    @(negedge clk);
    regSel = 1'b1; #1;
    chk(regRdData, 8'h00, "R1 mask at reset");
    @(negedge clk);

    // R5: reserved bit ignores event and write
    cyc(8'h02, 1, 1, 8'hFF, 0, 0);
    cyc(8'h00, 0, 1, 8'h00, 0, 0);
    chk(regRdData, 8'hFD, "R5 mask bit1 zero");
    cyc(8'h00, 0, 0, 8'h00, 0, 0);
    chk(regRdData, 8'h00, "R5 flag bit1 ignores event");

    // R2 + R8: all sources pending, vector 3 first
    cyc(8'hFD, 0, 0, 8'h00, 0, 1);
    chk({4'd0, irqVec}, 8'd3, "R8 lowest vector 3");
    // R9: ack walks down the vectors 3..9
    for (int k = 0; k < 7; k++) cyc(8'h00, 0, 0, 8'h00, 1, 1);
    chk({7'd0, irqReq}, 8'h00, "R9 all acked");
    cyc(8'h00, 0, 0, 8'h00, 0, 1);
    chk(regRdData, 8'h00, "R9 flags cleared by ack");
    // R9: ack without request has no effect
    cyc(8'h01, 0, 1, 8'h00, 0, 0);
    cyc(8'h00, 0, 0, 8'h00, 1, 0);
    chk(regRdData, 8'h01, "R9 ack ignored when idle");
    cyc(8'h00, 0, 0, 8'h00, 0, 1);
    chk({4'd0, irqVec}, 8'd9, "R7 timer0 vector 9");
    // R3: zeros leave flags, ones clear
    cyc(8'h30, 0, 0, 8'h00, 0, 0);
    cyc(8'h00, 1, 0, 8'h20, 0, 0);
    cyc(8'h00, 0, 0, 8'h00, 0, 0);
    chk(regRdData, 8'h11, "R3 partial clear");
    // R10: event and write clear in same cycle
    cyc(8'h10, 1, 0, 8'h10, 0, 0);
    cyc(8'h00, 0, 0, 8'h00, 0, 0);
    chk(regRdData, 8'h11, "R10 event beats write clear");
    // R10: event and ack on same flag
    cyc(8'h00, 1, 1, 8'h01, 0, 1);
    cyc(8'h01, 0, 0, 8'h00, 1, 1);
    chk({4'd0, irqVec}, 8'd9, "R10 event beats ack clear");
    // R6: mask off drops request
    cyc(8'h00, 1, 1, 8'h00, 0, 1);
    chk({7'd0, irqReq}, 8'h00, "R6 masked no request");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ev;
      ev = '0;
      for (int b = 0; b < 8; b++) ev[b] = ($urandom % 10) == 0;
      cyc(ev, ($urandom % 6) == 0, $urandom % 2, 8'($urandom),
          ($urandom % 3) == 0, ($urandom % 8) != 0);
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule